// File: doc/BRIEF.md
# Three-Level Virtual Address Translation Walker

This block turns a 39-bit virtual address into a 56-bit physical address by walking a radix tree of page tables held in memory. A client hands it the virtual address, the physical base of the top table, the level at which to start, the kind of access (load, store or instruction fetch), the privilege of the requester, the make-executable-readable and supervisor-user-access controls, and an incoming global flag. The walker then reads one 8-byte table entry per level over a simple request/response memory port, until it reaches a leaf or meets a fault.

A walk ends in one of two ways. On success the walker returns the physical address, the leaf entry itself, the address the leaf was read from, the level it was found at, and the accumulated global flag. On failure it returns one of four fault codes. Updating the accessed and dirty bits is left to the translation controller that uses this block, so the walker never writes memory.

Only one walk runs at a time. `busy` is high from the cycle after a request is taken until the result has been shown, and the result ports are meaningful only in the single cycle in which `done` is high.

Top module: `vm_walker`

## Requirements
- R1: A request on `req_valid` is taken only while `busy` is low. `busy` is high in the next cycle. Requests made while `busy` is high are ignored. `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R2: Each level issues one single-cycle `mem_req_valid` pulse. The address is the current table base plus 8 times the 9-bit slice of the virtual page number (bits 38:12) selected by shifting right by 9 times the level. A walk that starts at level L makes at most L+1 reads.
- R3: A response with `mem_rsp_err` high ends the walk with fault code 0 (access).
- R4: An entry with V (bit 0) clear, or with W (bit 2) set and R (bit 1) clear, ends the walk with fault code 1 (invalid entry).
- R5: An entry with V set and R, W and X (bit 3) all clear points to the next table. Above level 0, the walk continues one level lower from base = PPN (bits 53:10) shifted left by 12. At level 0 such an entry gives fault code 1.
- R6: The returned global flag is the OR of `req_global` and the G bit (bit 5) of every entry read on the walk.
- R7: A leaf that fails the permission check gives fault code 2. The check works as follows. A load (`req_acc`=0) needs R, or X when `req_mxr` is set. A store (1) needs W. A fetch (2) needs X. Code 3 is never permitted. A user request (`req_user`=1) needs U (bit 4). A supervisor request may use a U page only for loads or stores, and only with `req_sum` set.
- R8: A permitted leaf above level 0 whose PPN has any bit set below bit 9 times the level gives fault code 3 (misaligned). Permission is checked before alignment.
- R9: On success the physical page number is the leaf PPN, ORed at a superpage with the virtual page number bits below bit 9 times the level.
- R10: On success `res_pte`, `res_pte_addr` and `res_level` give the leaf entry, the address it was read from, and its level.
- R11: On success `res_paddr[11:0]` equals the request's virtual address bits 11:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_vaddr | input | 39 | Virtual address to translate |
| req_root | input | 56 | Physical base of the starting table |
| req_level | input | 2 | Starting level, 0 to 2 |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for a user-mode request, 0 for supervisor |
| req_mxr | input | 1 | Loads may use execute-only pages |
| req_sum | input | 1 | Supervisor data access to user pages allowed |
| req_global | input | 1 | Incoming global flag |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Table entry read request, one cycle |
| mem_req_addr | output | 56 | Address of the entry to read |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_err | input | 1 | Read response is an error |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | Result valid this cycle |
| fault | output | 1 | Walk failed |
| fault_code | output | 2 | 0 access, 1 invalid, 2 permission, 3 misaligned |
| res_paddr | output | 56 | Translated physical address |
| res_pte | output | 64 | Leaf entry |
| res_pte_addr | output | 56 | Address of the leaf entry |
| res_level | output | 2 | Level of the leaf |
| res_global | output | 1 | Accumulated global flag |

## Verification
The checker watches the handshake shape on every cycle: acceptance raises `busy`, `done` and `mem_req_valid` are single-cycle pulses, and reads appear only inside a walk. It also checks properties that hold for every result: the page offset carried through to a successful result, misaligned faults reported only above level 0, and a level-0 result using the leaf PPN unchanged. Other behaviour can only be shown by driving scenarios through a memory model and comparing against a reference walk. This covers the fault classification and its priority, the permission matrix under MXR and SUM, superpage merging, the sticky global flag, and the number and addresses of the reads.

// File: rtl/vm_walk_pkg.sv
package vm_walk_pkg;

  // Entry flag positions; neighbours decode these
  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_X = 3;
  localparam int PTE_U = 4;
  localparam int PTE_G = 5;
  localparam int PPN_LSB = 10;

  typedef enum logic [1:0] {
    FLT_ACCESS   = 2'd0,
    FLT_INVALID  = 2'd1,
    FLT_PERM     = 2'd2,
    FLT_MISALIGN = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DONE  = 2'd3
  } walk_st_e;

endpackage

// File: rtl/vm_walk_index.sv
// Entry address for the current level: base + slice * entry size
module vm_walk_index #(
  parameter int VPN_W   = 27,
  parameter int SLICE_W = 9,
  parameter int PA_W    = 56,
  parameter int LVL_W   = 2,
  parameter int PTE_LOG = 3
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  input  logic [PA_W-1:0]  base,
  output logic [PA_W-1:0]  addr
);
  localparam int PAD_W = PA_W - SLICE_W - PTE_LOG;

  logic [VPN_W-1:0]   shifted;
  logic [SLICE_W-1:0] idx;

  always_comb begin
    shifted = vpn >> (int'(level) * SLICE_W);
    idx     = shifted[SLICE_W-1:0];
    addr    = base + {{PAD_W{1'b0}}, idx, {PTE_LOG{1'b0}}};
  end
endmodule

// File: rtl/vm_pte_judge.sv
// Entry classification and leaf permission check
module vm_pte_judge
  import vm_walk_pkg::*;
(
  input  logic [4:0] flags,
  input  logic [1:0] acc,
  input  logic       user,
  input  logic       mxr,
  input  logic       sum,
  output logic       is_invalid,
  output logic       is_pointer,
  output logic       perm_ok
);
  logic v, r, w, x, u;
  logic kind_ok, priv_ok;

  always_comb begin
    v = flags[PTE_V];
    r = flags[PTE_R];
    w = flags[PTE_W];
    x = flags[PTE_X];
    u = flags[PTE_U];
    is_invalid = !v || (w && !r);
    is_pointer = v && !r && !w && !x;
    unique case (acc)
      ACC_LOAD:  kind_ok = r || (mxr && x);
      ACC_STORE: kind_ok = w;
      ACC_FETCH: kind_ok = x;
      default:   kind_ok = 1'b0;
    endcase
    if (user) priv_ok = u;
    else      priv_ok = !u || (sum && (acc != ACC_FETCH));
    perm_ok = kind_ok && priv_ok;
  end
endmodule

// File: rtl/vm_leaf_merge.sv
// Superpage alignment test and page-number merge
module vm_leaf_merge #(
  parameter int PPN_W   = 44,
  parameter int VPN_W   = 27,
  parameter int SLICE_W = 9,
  parameter int LVL_W   = 2
) (
  input  logic [PPN_W-1:0] ppn_in,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic             misaligned,
  output logic [PPN_W-1:0] ppn_out
);
  logic [PPN_W-1:0] mask;
  logic [PPN_W-1:0] vpn_ext;

  for (genvar i = 0; i < PPN_W; i++) begin : g_mask
    assign mask[i] = (i < int'(level) * SLICE_W);
  end

  always_comb begin
    vpn_ext    = {{(PPN_W-VPN_W){1'b0}}, vpn};
    misaligned = |(ppn_in & mask);
    ppn_out    = ppn_in | (vpn_ext & mask);
  end
endmodule

// File: rtl/vm_walker.sv
module vm_walker
  import vm_walk_pkg::*;
#(
  parameter int VA_W    = 39,
  parameter int PA_W    = 56,
  parameter int PGOFS_W = 12,
  parameter int SLICE_W = 9,
  parameter int LVL_W   = 2,
  parameter int PTE_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   req_root,
  input  logic [LVL_W-1:0]  req_level,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic              req_mxr,
  input  logic              req_sum,
  input  logic              req_global,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic [PA_W-1:0]   res_paddr,
  output logic [PTE_W-1:0]  res_pte,
  output logic [PA_W-1:0]   res_pte_addr,
  output logic [LVL_W-1:0]  res_level,
  output logic              res_global
);
  localparam int VPN_W   = VA_W - PGOFS_W;
  localparam int PPN_W   = PA_W - PGOFS_W;
  localparam int PTE_LOG = $clog2(PTE_W / 8);

  walk_st_e st_q, st_d;

  // walk context
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [PA_W-1:0]  base_q, base_d;
  logic             glob_q, glob_d;
  logic [VA_W-1:0]  vaddr_q;
  logic [1:0]       acc_q;
  logic             user_q, mxr_q, sum_q;
  logic             ctx_en, cap_req;

  // result
  logic             res_en;
  logic             fault_q, fault_d;
  flt_e             code_q, code_d;
  logic [PA_W-1:0]  paddr_q, pte_addr_q;
  logic [PTE_W-1:0] pte_q;
  logic [LVL_W-1:0] rlvl_q;
  logic             rglob_q;

  logic [PA_W-1:0]  cur_addr;
  logic             e_invalid, e_pointer, e_perm_ok, e_misaligned;
  logic [PPN_W-1:0] leaf_ppn, merged_ppn;

  assign leaf_ppn = mem_rsp_data[PPN_LSB +: PPN_W];

  vm_walk_index #(
    .VPN_W(VPN_W), .SLICE_W(SLICE_W), .PA_W(PA_W), .LVL_W(LVL_W), .PTE_LOG(PTE_LOG)
  ) u_index (
    .vpn(vaddr_q[VA_W-1:PGOFS_W]), .level(lvl_q), .base(base_q), .addr(cur_addr)
  );

  vm_pte_judge u_judge (
    .flags(mem_rsp_data[4:0]), .acc(acc_q), .user(user_q), .mxr(mxr_q), .sum(sum_q),
    .is_invalid(e_invalid), .is_pointer(e_pointer), .perm_ok(e_perm_ok)
  );

  vm_leaf_merge #(
    .PPN_W(PPN_W), .VPN_W(VPN_W), .SLICE_W(SLICE_W), .LVL_W(LVL_W)
  ) u_merge (
    .ppn_in(leaf_ppn), .vpn(vaddr_q[VA_W-1:PGOFS_W]), .level(lvl_q),
    .misaligned(e_misaligned), .ppn_out(merged_ppn)
  );

  // next state
  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    glob_d  = glob_q;
    ctx_en  = 1'b0;
    cap_req = 1'b0;
    res_en  = 1'b0;
    fault_d = 1'b1;
    code_d  = FLT_ACCESS;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          st_d    = S_ISSUE;
          lvl_d   = req_level;
          base_d  = req_root;
          glob_d  = req_global;
          ctx_en  = 1'b1;
          cap_req = 1'b1;
        end
      end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT: begin
        if (mem_rsp_valid) begin
          st_d = S_DONE;
          if (mem_rsp_err) begin
            res_en = 1'b1;
            code_d = FLT_ACCESS;
          end else if (e_invalid) begin
            res_en = 1'b1;
            code_d = FLT_INVALID;
          end else if (e_pointer) begin
            if (lvl_q == '0) begin
              res_en = 1'b1;
              code_d = FLT_INVALID;
            end else begin
              st_d   = S_ISSUE;
              ctx_en = 1'b1;
              lvl_d  = lvl_q - LVL_W'(1);
              base_d = {leaf_ppn, {PGOFS_W{1'b0}}};
              glob_d = glob_q | mem_rsp_data[PTE_G];
            end
          end else if (!e_perm_ok) begin
            res_en = 1'b1;
            code_d = FLT_PERM;
          end else if (e_misaligned) begin
            res_en = 1'b1;
            code_d = FLT_MISALIGN;
          end else begin
            res_en  = 1'b1;
            fault_d = 1'b0;
          end
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  // walk context registers
  always_ff @(posedge clk) begin
    if (ctx_en) begin
      lvl_q  <= lvl_d;
      base_q <= base_d;
      glob_q <= glob_d;
    end
    if (cap_req) begin
      vaddr_q <= req_vaddr;
      acc_q   <= req_acc;
      user_q  <= req_user;
      mxr_q   <= req_mxr;
      sum_q   <= req_sum;
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (res_en) begin
      fault_q    <= fault_d;
      code_q     <= code_d;
      paddr_q    <= {merged_ppn, vaddr_q[PGOFS_W-1:0]};
      pte_q      <= mem_rsp_data;
      pte_addr_q <= cur_addr;
      rlvl_q     <= lvl_q;
      rglob_q    <= glob_q | mem_rsp_data[PTE_G];
    end
  end

  assign busy          = (st_q != S_IDLE);
  assign done          = (st_q == S_DONE);
  assign mem_req_valid = (st_q == S_ISSUE);
  assign mem_req_addr  = cur_addr;
  assign fault         = fault_q;
  assign fault_code    = code_q;
  assign res_paddr     = paddr_q;
  assign res_pte       = pte_q;
  assign res_pte_addr  = pte_addr_q;
  assign res_level     = rlvl_q;
  assign res_global    = rglob_q;

endmodule

// File: rtl/vm_walker_chk.sv
module vm_walker_chk #(
  parameter int VA_W    = 39,
  parameter int PA_W    = 56,
  parameter int PGOFS_W = 12,
  parameter int LVL_W   = 2,
  parameter int PTE_W   = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             done,
  input logic             fault,
  input logic [1:0]       fault_code,
  input logic [PA_W-1:0]  res_paddr,
  input logic [PTE_W-1:0] res_pte,
  input logic [LVL_W-1:0] res_level
);
  localparam int PPN_W = PA_W - PGOFS_W;

  logic [PGOFS_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 off_q <= '0;
    else if (req_valid && !busy) off_q <= req_vaddr[PGOFS_W-1:0];
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R2
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R2
  read_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy && !done);

  // R11
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> res_paddr[PGOFS_W-1:0] == off_q);

  // R8
  misalign_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault && fault_code == 2'd3 |-> res_level != '0);

  // R9
  base_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && res_level == '0 |-> res_paddr[PA_W-1:PGOFS_W] == res_pte[10 +: PPN_W]);

endmodule

bind vm_walker vm_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PGOFS_W(PGOFS_W), .LVL_W(LVL_W), .PTE_W(PTE_W)
) u_walker_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .busy(busy), .mem_req_valid(mem_req_valid), .done(done), .fault(fault),
  .fault_code(fault_code), .res_paddr(res_paddr), .res_pte(res_pte), .res_level(res_level)
);

// File: tb/test_vm_walker.sv
module test_vm_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid;
  logic [38:0] req_vaddr;
  logic [55:0] req_root;
  logic [1:0]  req_level, req_acc;
  logic        req_user, req_mxr, req_sum, req_global;
  logic        busy, mem_req_valid, mem_rsp_valid, mem_rsp_err;
  logic [55:0] mem_req_addr;
  logic [63:0] mem_rsp_data;
  logic        done, fault, res_global;
  logic [1:0]  fault_code, res_level;
  logic [55:0] res_paddr, res_pte_addr;
  logic [63:0] res_pte;

  vm_walker i_vm_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_root(req_root), .req_level(req_level), .req_acc(req_acc), .req_user(req_user),
    .req_mxr(req_mxr), .req_sum(req_sum), .req_global(req_global), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_code(fault_code), .res_paddr(res_paddr),
    .res_pte(res_pte), .res_pte_addr(res_pte_addr), .res_level(res_level),
    .res_global(res_global)
  );

  int n_chk = 0, n_fail = 0, n_req = 0;
  bit rand_fill = 0;
  logic [63:0] tbl [logic [55:0]];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1: act=running exp=finished");
    summary();
    $finish;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(logic [43:0] ppn, logic [7:0] fl);
    return {10'h0, ppn, 2'b00, fl};
  endfunction

  function automatic logic [63:0] rnd_pte();
    logic [63:0] r;
    logic [43:0] ppn;
    logic [2:0]  rwx;
    logic [7:0]  fl;
    r   = {$urandom, $urandom};
    ppn = r[43:0];
    case ($urandom % 4)
      0: ppn[17:0] = '0;
      1: ppn[8:0]  = '0;
      default: ;
    endcase
    ppn[43] = (($urandom % 16) == 0);
    rwx = (($urandom % 8) < 3) ? 3'b000 : 3'($urandom);
    fl  = {2'($urandom), 1'($urandom), 1'($urandom), rwx, 1'(($urandom % 8) != 0)};
    return mk_pte(ppn, fl);
  endfunction

  // memory responder: latency 1..3 cycles, error on address bit 55
  initial begin
    int pend;
    logic [55:0] a;
    pend = 0;
    mem_rsp_valid = 1'b0;
    mem_rsp_err = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_err = a[55];
          if (!tbl.exists(a) && rand_fill) tbl[a] = rnd_pte();
          mem_rsp_data = tbl.exists(a) ? tbl[a] : 64'h0;
        end
      end else if (mem_req_valid) begin
        a = mem_req_addr;
        n_req++;
        pend = 1 + int'($urandom % 3);
      end
    end
  end

  task automatic ref_walk(input logic [38:0] va, input logic [55:0] root, input int lvl0,
                          input logic [1:0] acc, input bit usr, input bit mxr, input bit sum,
                          input bit gin, output bit f, output logic [1:0] code,
                          output logic [55:0] pa, output logic [63:0] pte,
                          output logic [55:0] pte_a, output int lvl_o, output bit g_o,
                          output int reads);
    logic [26:0] vpn;
    int lv;
    logic [55:0] b;
    bit g;
    vpn = va[38:12]; lv = lvl0; b = root; g = gin; reads = 0;
    f = 1; code = 0; pa = 0; pte = 0; pte_a = 0; lvl_o = lv; g_o = 0;
    for (int k = 0; k < 3; k++) begin
      logic [8:0]  idx;
      logic [55:0] a;
      logic [63:0] p;
      logic [43:0] ppn, msk;
      bit okt, okp;
      idx = 9'((vpn >> (9 * lv)) & 27'h1ff);
      a = b + {44'h0, idx, 3'b000};
      reads++; pte_a = a; lvl_o = lv;
      if (a[55]) begin code = 0; return; end
      p = tbl.exists(a) ? tbl[a] : 64'h0;
      pte = p;
      g = g | p[5];
      if (!p[0] || (p[2] && !p[1])) begin code = 1; return; end
      if (p[3:1] == 3'b000) begin
        if (lv == 0) begin code = 1; return; end
        b = {p[53:10], 12'h000};
        lv--;
        continue;
      end
      okt = (acc == 0) ? (p[1] | (mxr & p[3])) : (acc == 1) ? p[2] : (acc == 2) ? p[3] : 1'b0;
      okp = usr ? p[4] : (!p[4] || (sum && acc != 2));
      if (!(okt && okp)) begin code = 2; return; end
      ppn = p[53:10];
      msk = (44'h1 << (9 * lv)) - 44'h1;
      if ((ppn & msk) != 0) begin code = 3; return; end
      ppn = ppn | ({17'h0, vpn} & msk);
      f = 0; pa = {ppn, va[11:0]}; g_o = g;
      return;
    end
  endtask

  int reads_seen;

  task automatic go(logic [38:0] va, logic [55:0] root, logic [1:0] lvl, logic [1:0] acc,
                    bit usr, bit mxr, bit sum, bit gin);
    int start;
    @(negedge clk);
    req_vaddr = va; req_root = root; req_level = lvl; req_acc = acc;
    req_user = usr; req_mxr = mxr; req_sum = sum; req_global = gin;
    start = n_req;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    reads_seen = n_req - start;
  endtask

  // compare the result shown with done against the reference walk
  task automatic cmp_ref(string tag, logic [38:0] va, logic [55:0] root, int lvl,
                         logic [1:0] acc, bit usr, bit mxr, bit sum, bit gin);
    bit ef, eg; logic [1:0] ec; logic [55:0] epa, epta; logic [63:0] ep; int el, er;
    ref_walk(va, root, lvl, acc, usr, mxr, sum, gin, ef, ec, epa, ep, epta, el, eg, er);
    chk({tag, " R3/R4/R7/R8 fault"}, 64'(fault), 64'(ef));
    chk({tag, " R2 read count"}, 64'(reads_seen), 64'(er));
    if (ef) chk({tag, " R3/R4/R5/R7/R8 code"}, 64'(fault_code), 64'(ec));
    else begin
      chk({tag, " R9 paddr"}, 64'(res_paddr), 64'(epa));
      chk({tag, " R10 pte"}, res_pte, ep);
      chk({tag, " R10 pte addr"}, 64'(res_pte_addr), 64'(epta));
      chk({tag, " R10 level"}, 64'(res_level), 64'(el));
      chk({tag, " R6 global"}, 64'(res_global), 64'(eg));
    end
  endtask

  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08, FU = 8'h10, FG = 8'h20;
  localparam logic [38:0] VA_D = {9'd1, 9'd2, 9'd3, 12'hABC};

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_root = '0; req_level = '0;
    req_acc = '0; req_user = 0; req_mxr = 0; req_sum = 0; req_global = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset busy", 64'(busy), 64'h0);
    chk("R1 reset done", 64'(done), 64'h0);
    chk("R2 reset read", 64'(mem_req_valid), 64'h0);
    rst_n = 1'b1;

    // R9 R10 level-1 superpage through a pointer
    tbl.delete();
    tbl[56'h1008] = mk_pte(44'h2, FV);
    tbl[56'h2010] = mk_pte(44'h400, FV | FR | FW | 8'hC0);
    go(VA_D, 56'h1000, 2, 0, 0, 0, 0, 0);
    chk("R9 superpage paddr", 64'(res_paddr), 64'h403ABC);
    chk("R10 level", 64'(res_level), 64'd1);
    chk("R10 pte addr", 64'(res_pte_addr), 64'h2010);
    chk("R2 two reads", 64'(reads_seen), 64'd2);
    chk("R6 global clear", 64'(res_global), 64'h0);

    // R8 misaligned level-2 leaf
    tbl.delete();
    tbl[56'h1008] = mk_pte(44'h100, FV | FR);
    go(VA_D, 56'h1000, 2, 0, 0, 0, 0, 0);
    chk("R8 misaligned", 64'({fault, fault_code}), 64'h7);
    // R8 permission wins over alignment
    tbl[56'h1008] = mk_pte(44'h100, FV | FX);
    go(VA_D, 56'h1000, 2, 0, 0, 0, 0, 0);
    chk("R8 perm before align", 64'({fault, fault_code}), 64'h6);

    // R5 pointer at level 0
    tbl.delete();
    tbl[56'h3018] = mk_pte(44'h9, FV);
    go(VA_D, 56'h3000, 0, 0, 0, 0, 0, 0);
    chk("R5 pointer at level 0", 64'({fault, fault_code}), 64'h5);

    // R3 error response
    go(VA_D, 56'h80_0000_0000_0000, 0, 0, 0, 0, 0, 0);
    chk("R3 access fault", 64'({fault, fault_code}), 64'h4);

    // R6 global from a pointer and from the request
    tbl.delete();
    tbl[56'h1008] = mk_pte(44'h5, FV | FG);
    tbl[56'h5010] = mk_pte(44'h800, FV | FR);
    go(VA_D, 56'h1000, 2, 0, 0, 0, 0, 0);
    chk("R6 global from pointer", 64'(res_global), 64'h1);
    chk("R9 merge", 64'(res_paddr), 64'h803ABC);
    tbl[56'h6018] = mk_pte(44'h1234, FV | FR);
    go(VA_D, 56'h6000, 0, 0, 0, 0, 0, 1);
    chk("R6 global from request", 64'(res_global), 64'h1);
    chk("R11 offset", 64'(res_paddr), 64'h1234ABC);

    // R4 invalid encodings
    tbl.delete();
    tbl[56'h3018] = mk_pte(44'h1, FV | FW);
    go(VA_D, 56'h3000, 0, 1, 0, 0, 0, 0);
    chk("R4 write without read", 64'({fault, fault_code}), 64'h5);
    tbl[56'h3018] = mk_pte(44'h1, FR | FW | FX);
    go(VA_D, 56'h3000, 0, 0, 0, 0, 0, 0);
    chk("R4 not valid", 64'({fault, fault_code}), 64'h5);

    // R7 permission matrix
    tbl.delete();
    tbl[56'h3018] = mk_pte(44'h1, FV | FR);
    go(VA_D, 56'h3000, 0, 0, 1, 0, 0, 0);
    chk("R7 user on supervisor page", 64'({fault, fault_code}), 64'h6);
    go(VA_D, 56'h3000, 0, 1, 0, 0, 0, 0);
    chk("R7 store to read-only", 64'({fault, fault_code}), 64'h6);
    go(VA_D, 56'h3000, 0, 3, 0, 0, 0, 0);
    chk("R7 reserved access", 64'({fault, fault_code}), 64'h6);
    tbl[56'h3018] = mk_pte(44'h1, FV | FR | FX | FU);
    go(VA_D, 56'h3000, 0, 0, 0, 0, 0, 0);
    chk("R7 supervisor user page no sum", 64'({fault, fault_code}), 64'h6);
    go(VA_D, 56'h3000, 0, 0, 0, 0, 1, 0);
    chk("R7 supervisor user page sum", 64'(fault), 64'h0);
    go(VA_D, 56'h3000, 0, 2, 0, 0, 1, 0);
    chk("R7 supervisor fetch user page", 64'({fault, fault_code}), 64'h6);
    go(VA_D, 56'h3000, 0, 2, 1, 0, 0, 0);
    chk("R7 user fetch user page", 64'(fault), 64'h0);
    tbl[56'h3018] = mk_pte(44'h1, FV | FX);
    go(VA_D, 56'h3000, 0, 0, 0, 0, 0, 0);
    chk("R7 load execute-only", 64'({fault, fault_code}), 64'h6);
    go(VA_D, 56'h3000, 0, 0, 0, 1, 0, 0);
    chk("R7 load execute-only mxr", 64'(fault), 64'h0);

    // R1 requests while busy are ignored
    tbl.delete();
    tbl[56'h3018] = mk_pte(44'h1234, FV | FR);
    @(negedge clk);
    req_vaddr = VA_D; req_root = 56'h3000; req_level = 0; req_acc = 0;
    req_user = 0; req_mxr = 0; req_sum = 0; req_global = 0;
    reads_seen = n_req;
    req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = {9'd7, 9'd7, 9'd7, 12'h123}; req_root = 56'h9000;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R1 busy request ignored paddr", 64'(res_paddr), 64'h1234ABC);
    @(negedge clk);
    chk("R1 idle after done", 64'(busy), 64'h0);
    @(negedge clk);
    chk("R1 no second walk", 64'(busy), 64'h0);
    chk("R2 single read", 64'(n_req - reads_seen), 64'd1);

    // random walks against the reference model
    rand_fill = 1;
    for (int n = 0; n < 400; n++) begin
      logic [38:0] va;
      logic [63:0] r;
      logic [55:0] root;
      int lv;
      logic [1:0] acc;
      bit usr, mxr, sum, gin;
      tbl.delete();
      r    = {$urandom, $urandom};
      va   = r[38:0];
      r    = {$urandom, $urandom};
      root = {(($urandom % 16) == 0), r[42:0], 12'h000};
      lv   = int'($urandom % 3);
      acc  = 2'($urandom);
      usr  = 1'($urandom); mxr = 1'($urandom); sum = 1'($urandom); gin = (($urandom % 4) == 0);
      go(va, root, 2'(lv), acc, usr, mxr, sum, gin);
      cmp_ref("random", va, root, lv, acc, usr, mxr, sum, gin);
    end

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule